// File: doc/BRIEF.md
# Fracturable Multiply-Accumulate Unit

This block is a signed multiply-add/subtract datapath. It takes two 18-bit operands and produces a 41-bit result. In full-width mode it forms the two's-complement value `P = C + A*B`, or `P = C - A*B` when subtraction is selected. It also flags a result that does not fit in 41 signed bits.

In split mode the multiplier breaks into two independent 9x9 signed lanes:

- The low lane returns a plain product in `P[17:0]`.
- The high lane accumulates into `P[40:18]` and keeps its own overflow flag.

The addend `C` comes from one of three sources: the routed input, the cascade input, or the registered result fed back. In full-width mode `C` can be arithmetically shifted right by 17 bits before the adder, which lets long accumulations carry into a wider result across chained units. The cascade output always mirrors `P`.

Every storage stage is split into a high half on `clk_hi` and a low half on `clk_lo`. The stages are the operand registers, the result register and the four control-bit registers. Each half has its own bypass, enable, asynchronous reset and synchronous reset. Selecting feedback while the upper result register is bypassed is an illegal setting. In that case the unit forces `C` to zero and raises `config_error`.

Top module: `fmac_unit`

## Requirements
- R1: With `split_mode`=0, `P` equals the low 41 bits of `C + A*B` when `sub`=0 and of `C - A*B` when `sub`=1, where A and B are 18-bit signed and C is 41-bit signed.
- R2: With `split_mode`=1, `P[17:0]` equals the signed product `A[8:0]*B[8:0]`, and it never accumulates.
- R3: With `split_mode`=1, `P[40:18]` equals `C[40:18] +/- A[17:9]*B[17:9]`, with the sign set by `sub` (1 = subtract).
- R4: With `split_mode`=0, `ovfl` is 1 exactly when the unrounded result is above 2^40-1 or below -2^40.
- R5: With `split_mode`=1, `ovfl` is 1 exactly when the high-lane result is above 2^22-1 or below -2^22. The low lane never sets it.
- R6: `C` is selected with `casc_sel` taking priority: `casc_sel`=1 selects `casc_in`; otherwise `fb_sel`=1 selects the registered result; otherwise `c_in` is used.
- R7: With `split_mode`=0 and `shift_en`=1, `C` is shifted right arithmetically by 17 bits before the adder. In split mode `shift_en` has no effect.
- R8: In split mode bits [17:0] of the selected `C` have no effect on `P` or `ovfl`.
- R9: Each half of each register stage is transparent when its bypass bit is 1. When the bypass bit is 0, a change on its input reaches `P` only after the next rising edge of that half's clock. Bit index 1 is the high half and bit index 0 the low half. Control bits are indexed 0=`sub`, 1=`shift_en`, 2=`casc_sel`, 3=`fb_sel`.
- R10: A registered half with its enable at 0, and no reset active, holds its value across clock edges.
- R11: A low asynchronous reset clears a register half at once. Otherwise a low synchronous reset clears it at the next edge, regardless of enable. All reset values are zero.
- R12: `casc_out` equals `P` at all times.
- R13: When `fb_sel`=1, `casc_sel`=0 and `p_bypass[1]`=1, `config_error` is 1 and `C` is treated as zero. Otherwise `config_error` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_hi | input | 1 | Clock for the high halves, the overflow flag and the control bits |
| clk_lo | input | 1 | Clock for the low operand and result halves |
| split_mode | input | 1 | 1 = two 9x9 lanes, 0 = full width |
| a | input | 18 | Multiplier operand A, signed |
| b | input | 18 | Multiplier operand B, signed |
| c_in | input | 41 | Routed addend source |
| casc_in | input | 41 | Cascade addend source |
| sub | input | 1 | 1 = subtract the product |
| shift_en | input | 1 | 1 = shift C right by 17 (full width only) |
| casc_sel | input | 1 | Select the cascade source for C |
| fb_sel | input | 1 | Select result feedback for C |
| a_bypass | input | 2 | Operand A register bypass per half |
| a_en | input | 2 | Operand A register enable per half |
| a_arst_n | input | 2 | Operand A asynchronous reset, active low |
| a_srst_n | input | 2 | Operand A synchronous reset, active low |
| b_bypass | input | 2 | Operand B register bypass per half |
| b_en | input | 2 | Operand B register enable per half |
| b_arst_n | input | 2 | Operand B asynchronous reset, active low |
| b_srst_n | input | 2 | Operand B synchronous reset, active low |
| p_bypass | input | 2 | Result register bypass per half |
| p_en | input | 2 | Result register enable per half |
| p_arst_n | input | 2 | Result asynchronous reset, active low |
| p_srst_n | input | 2 | Result synchronous reset, active low |
| ctl_bypass | input | 4 | Control-bit register bypass |
| ctl_en | input | 4 | Control-bit register enable |
| ctl_arst_n | input | 4 | Control-bit asynchronous reset, active low |
| ctl_srst_n | input | 4 | Control-bit synchronous reset, active low |
| p | output | 41 | Result |
| ovfl | output | 1 | Overflow flag |
| casc_out | output | 41 | Cascade copy of the result |
| config_error | output | 1 | Illegal feedback setting detected |

## Verification
The checker properties assume that `clk_hi` and `clk_lo` are the same clock, because the lane-product and reset properties are each sampled on only one of them. They also assume that the bypass bits remain static between the cycle a property fires and the cycle it checks, apart from the cases the consequent exempts. The bench therefore drives both clocks from one source. It changes bypass and select settings only on falling edges, and it lets the result register settle for at least one edge before any hold or reset property depends on it. Operand tables run with every stage bypassed, so each expected value depends only on that row's inputs.

// File: rtl/fmac_pkg.sv
package fmac_pkg;
  localparam int A_W    = 18;
  localparam int LO_W   = A_W / 2;
  localparam int HI_W   = A_W - LO_W;
  localparam int P_W    = 41;
  localparam int P_LO_W = 2 * LO_W;
  localparam int P_HI_W = P_W - P_LO_W;
  localparam int SH_AMT = 17;
  localparam int NCTL   = 4;
  localparam int FW     = P_W + 2;       // full-width exact sum
  localparam int HW     = P_HI_W + 2;    // high-lane exact sum

  typedef struct packed {
    logic           ovf;
    logic [P_W-1:0] p;
  } mac_res_t;

  // full-width: C (optionally pre-shifted) +/- A*B with range check
  function automatic mac_res_t mac_full(input logic [A_W-1:0] a, input logic [A_W-1:0] b,
                                        input logic [P_W-1:0] c, input logic sub,
                                        input logic sh);
    logic signed [P_W-1:0] cs;
    logic [FW-1:0] ce, ae, be, pe, s;
    mac_res_t r;
    cs = sh ? ($signed(c) >>> SH_AMT) : $signed(c);
    ce = {{2{cs[P_W-1]}}, cs};
    ae = {{(FW-A_W){a[A_W-1]}}, a};
    be = {{(FW-A_W){b[A_W-1]}}, b};
    pe = ae * be;
    s  = sub ? (ce - pe) : (ce + pe);
    r.ovf = !((s[FW-1:P_W-1] == '0) || (s[FW-1:P_W-1] == '1));
    r.p   = s[P_W-1:0];
    return r;
  endfunction

  // split: independent low product, high lane accumulate
  function automatic mac_res_t mac_split(input logic [A_W-1:0] a, input logic [A_W-1:0] b,
                                         input logic [P_HI_W-1:0] ch, input logic sub);
    logic [P_LO_W-1:0] al, bl, pl;
    logic [HW-1:0] ce, ae, be, pe, s;
    mac_res_t r;
    al = {{(P_LO_W-LO_W){a[LO_W-1]}}, a[LO_W-1:0]};
    bl = {{(P_LO_W-LO_W){b[LO_W-1]}}, b[LO_W-1:0]};
    pl = al * bl;
    ce = {{2{ch[P_HI_W-1]}}, ch};
    ae = {{(HW-HI_W){a[A_W-1]}}, a[A_W-1:LO_W]};
    be = {{(HW-HI_W){b[A_W-1]}}, b[A_W-1:LO_W]};
    pe = ae * be;
    s  = sub ? (ce - pe) : (ce + pe);
    r.ovf = !((s[HW-1:P_HI_W-1] == '0) || (s[HW-1:P_HI_W-1] == '1));
    r.p   = {s[P_HI_W-1:0], pl};
    return r;
  endfunction
endpackage

// File: rtl/fmac_stage_reg.sv
module fmac_stage_reg #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         en,
  input  logic         arst_n,
  input  logic         srst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      q <= '0;
    else if (!srst_n) q <= '0;
    else if (en)      q <= d;
  end
endmodule

// File: rtl/fmac_opsel.sv
module fmac_opsel
  import fmac_pkg::*;
(
  input  logic           casc_sel,
  input  logic           fb_sel,
  input  logic           p_hi_bypass,
  input  logic [P_W-1:0] c_in,
  input  logic [P_W-1:0] casc_in,
  input  logic [P_W-1:0] p_fb,
  output logic [P_W-1:0] c_op,
  output logic           cfg_err
);
  always_comb begin
    cfg_err = fb_sel && !casc_sel && p_hi_bypass;
    if (casc_sel)     c_op = casc_in;
    else if (cfg_err) c_op = '0;
    else if (fb_sel)  c_op = p_fb;
    else              c_op = c_in;
  end
endmodule

// File: rtl/fmac_arith.sv
module fmac_arith
  import fmac_pkg::*;
(
  input  logic           split_mode,
  input  logic           sub,
  input  logic           shift_en,
  input  logic [A_W-1:0] a,
  input  logic [A_W-1:0] b,
  input  logic [P_W-1:0] c,
  output logic [P_W-1:0] p_nx,
  output logic           ovf_nx
);
  mac_res_t res;
  always_comb begin
    if (split_mode) res = mac_split(a, b, c[P_W-1:P_LO_W], sub);
    else            res = mac_full(a, b, c, sub, shift_en);
    p_nx   = res.p;
    ovf_nx = res.ovf;
  end
endmodule

// File: rtl/fmac_unit.sv
module fmac_unit
  import fmac_pkg::*;
(
  input  logic            clk_hi,
  input  logic            clk_lo,
  input  logic            split_mode,
  input  logic [A_W-1:0]  a,
  input  logic [A_W-1:0]  b,
  input  logic [P_W-1:0]  c_in,
  input  logic [P_W-1:0]  casc_in,
  input  logic            sub,
  input  logic            shift_en,
  input  logic            casc_sel,
  input  logic            fb_sel,
  input  logic [1:0]      a_bypass,
  input  logic [1:0]      a_en,
  input  logic [1:0]      a_arst_n,
  input  logic [1:0]      a_srst_n,
  input  logic [1:0]      b_bypass,
  input  logic [1:0]      b_en,
  input  logic [1:0]      b_arst_n,
  input  logic [1:0]      b_srst_n,
  input  logic [1:0]      p_bypass,
  input  logic [1:0]      p_en,
  input  logic [1:0]      p_arst_n,
  input  logic [1:0]      p_srst_n,
  input  logic [NCTL-1:0] ctl_bypass,
  input  logic [NCTL-1:0] ctl_en,
  input  logic [NCTL-1:0] ctl_arst_n,
  input  logic [NCTL-1:0] ctl_srst_n,
  output logic [P_W-1:0]  p,
  output logic            ovfl,
  output logic [P_W-1:0]  casc_out,
  output logic            config_error
);
  logic [1:0]      clk_v;
  logic [A_W-1:0]  a_eff, b_eff;
  logic [NCTL-1:0] ctl_d, ctl_r, ctl_eff;
  logic [P_W-1:0]  c_op, p_nx, p_fb;
  logic            ovf_nx;
  logic [P_LO_W-1:0] p_lo_r;
  logic [P_HI_W:0]   p_hi_r;     // {ovf, upper result}

  assign clk_v = {clk_hi, clk_lo};

  // operand registers, one pair per half
  for (genvar h = 0; h < 2; h++) begin : g_opnd
    localparam int LSB = (h == 0) ? 0 : LO_W;
    localparam int W   = (h == 0) ? LO_W : HI_W;
    logic [W-1:0] a_r, b_r;
    fmac_stage_reg #(.W(W)) u_a (
      .clk(clk_v[h]), .en(a_en[h]), .arst_n(a_arst_n[h]), .srst_n(a_srst_n[h]),
      .d(a[LSB +: W]), .q(a_r));
    fmac_stage_reg #(.W(W)) u_b (
      .clk(clk_v[h]), .en(b_en[h]), .arst_n(b_arst_n[h]), .srst_n(b_srst_n[h]),
      .d(b[LSB +: W]), .q(b_r));
    assign a_eff[LSB +: W] = a_bypass[h] ? a[LSB +: W] : a_r;
    assign b_eff[LSB +: W] = b_bypass[h] ? b[LSB +: W] : b_r;
  end

  // control-bit registers, all on the high clock
  assign ctl_d = {fb_sel, casc_sel, shift_en, sub};
  for (genvar i = 0; i < NCTL; i++) begin : g_ctl
    fmac_stage_reg #(.W(1)) u_c (
      .clk(clk_hi), .en(ctl_en[i]), .arst_n(ctl_arst_n[i]), .srst_n(ctl_srst_n[i]),
      .d(ctl_d[i +: 1]), .q(ctl_r[i +: 1]));
    assign ctl_eff[i] = ctl_bypass[i] ? ctl_d[i] : ctl_r[i];
  end

  // feedback always taps the flops, never the bypass path
  assign p_fb = {p_hi_r[P_HI_W-1:0], p_lo_r};

  fmac_opsel u_opsel (
    .casc_sel(ctl_eff[2]), .fb_sel(ctl_eff[3]), .p_hi_bypass(p_bypass[1]),
    .c_in(c_in), .casc_in(casc_in), .p_fb(p_fb), .c_op(c_op), .cfg_err(config_error));

  fmac_arith u_arith (
    .split_mode(split_mode), .sub(ctl_eff[0]), .shift_en(ctl_eff[1]),
    .a(a_eff), .b(b_eff), .c(c_op), .p_nx(p_nx), .ovf_nx(ovf_nx));

  fmac_stage_reg #(.W(P_LO_W)) u_p_lo (
    .clk(clk_lo), .en(p_en[0]), .arst_n(p_arst_n[0]), .srst_n(p_srst_n[0]),
    .d(p_nx[P_LO_W-1:0]), .q(p_lo_r));
  fmac_stage_reg #(.W(P_HI_W+1)) u_p_hi (
    .clk(clk_hi), .en(p_en[1]), .arst_n(p_arst_n[1]), .srst_n(p_srst_n[1]),
    .d({ovf_nx, p_nx[P_W-1:P_LO_W]}), .q(p_hi_r));

  assign p[P_LO_W-1:0]   = p_bypass[0] ? p_nx[P_LO_W-1:0] : p_lo_r;
  assign p[P_W-1:P_LO_W] = p_bypass[1] ? p_nx[P_W-1:P_LO_W] : p_hi_r[P_HI_W-1:0];
  assign ovfl            = p_bypass[1] ? ovf_nx : p_hi_r[P_HI_W];
  assign casc_out        = p;
endmodule

// File: rtl/fmac_unit_chk.sv
module fmac_unit_chk
  import fmac_pkg::*;
(
  input logic           clk_hi,
  input logic           clk_lo,
  input logic           split_mode,
  input logic [A_W-1:0] a,
  input logic [A_W-1:0] b,
  input logic [1:0]     a_bypass,
  input logic [1:0]     b_bypass,
  input logic [1:0]     p_bypass,
  input logic [1:0]     p_en,
  input logic [1:0]     p_arst_n,
  input logic [1:0]     p_srst_n,
  input logic [P_W-1:0] p,
  input logic           ovfl,
  input logic           config_error,
  input logic [P_W-1:0] c_op
);
  logic [P_LO_W-1:0] lo_ref;
  assign lo_ref = {{(P_LO_W-LO_W){a[LO_W-1]}}, a[LO_W-1:0]} *
                  {{(P_LO_W-LO_W){b[LO_W-1]}}, b[LO_W-1:0]};

  // R2: registered low lane holds last product, not a running sum
  a_r2_lane_lo: assert property (@(posedge clk_lo) disable iff (!p_arst_n[0])
    (split_mode && a_bypass[0] && b_bypass[0] && !p_bypass[0] && p_en[0] && p_srst_n[0])
    |=> (p_bypass[0] || p[P_LO_W-1:0] == $past(lo_ref)));

  a_r10_hold_hi: assert property (@(posedge clk_hi) disable iff (!p_arst_n[1])
    (!p_bypass[1] && !p_en[1] && p_srst_n[1])
    |=> (p_bypass[1] || ($stable(p[P_W-1:P_LO_W]) && $stable(ovfl))));

  a_r11_srst_lo: assert property (@(posedge clk_lo) disable iff (!p_arst_n[0])
    (!p_srst_n[0]) |=> (p_bypass[0] || p[P_LO_W-1:0] == '0));

  a_r11_srst_hi: assert property (@(posedge clk_hi) disable iff (!p_arst_n[1])
    (!p_srst_n[1]) |=> (p_bypass[1] || (p[P_W-1:P_LO_W] == '0 && !ovfl)));

  a_r13_cfg_zero: assert property (@(posedge clk_hi) disable iff (!p_arst_n[1])
    config_error |-> (c_op == '0));
endmodule

bind fmac_unit fmac_unit_chk chk_i (
  .clk_hi, .clk_lo, .split_mode, .a, .b, .a_bypass, .b_bypass, .p_bypass,
  .p_en, .p_arst_n, .p_srst_n, .p, .ovfl, .config_error, .c_op);

// File: tb/fmac_unit_tb.sv
`timescale 1ns/1ps
module fmac_unit_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        split_mode, sub, shift_en, casc_sel, fb_sel;
  logic [17:0] a, b;
  logic [40:0] c_in, casc_in, p, casc_out;
  logic [1:0]  a_bypass, a_en, a_arst_n, a_srst_n, b_bypass, b_en, b_arst_n, b_srst_n;
  logic [1:0]  p_bypass, p_en, p_arst_n, p_srst_n;
  logic [3:0]  ctl_bypass, ctl_en, ctl_arst_n, ctl_srst_n;
  logic        ovfl, config_error;

  int checks = 0;
  int errors = 0;

  fmac_unit dut_i (
    .clk_hi(clk), .clk_lo(clk), .split_mode, .a, .b, .c_in, .casc_in, .sub, .shift_en,
    .casc_sel, .fb_sel, .a_bypass, .a_en, .a_arst_n, .a_srst_n, .b_bypass, .b_en,
    .b_arst_n, .b_srst_n, .p_bypass, .p_en, .p_arst_n, .p_srst_n, .ctl_bypass, .ctl_en,
    .ctl_arst_n, .ctl_srst_n, .p, .ovfl, .casc_out, .config_error);

  // row: split, sub, shift, casc_sel, fb_sel, a, b, c_in, casc_in
  localparam int NV = 11;
  localparam logic [122:0] VEC [NV] = '{
    {1'b0,1'b0,1'b0,1'b0,1'b0, 18'd100, 18'd200, 41'd5, 41'd0},
    {1'b0,1'b1,1'b0,1'b0,1'b0, 18'h3FFF9, 18'd9, 41'd1000, 41'd0},
    {1'b0,1'b0,1'b0,1'b0,1'b0, 18'h1FFFF, 18'h1FFFF, 41'h0FFFFFFFFFF, 41'd0},
    {1'b0,1'b1,1'b0,1'b0,1'b0, 18'h1FFFF, 18'h1FFFF, 41'h10000000000, 41'd0},
    {1'b0,1'b0,1'b1,1'b0,1'b0, 18'd2, 18'd3, 41'h00100000000, 41'd0},
    {1'b0,1'b0,1'b1,1'b0,1'b0, 18'd0, 18'd0, 41'h1FFFFFFFFFB, 41'd0},
    {1'b0,1'b0,1'b0,1'b1,1'b0, 18'd11, 18'd13, 41'd999, 41'd12345},
    {1'b1,1'b0,1'b1,1'b0,1'b0, {9'h1FF,9'h0FF}, {9'd3,9'h100}, 41'h001C003FFFF, 41'd0},
    {1'b1,1'b0,1'b0,1'b0,1'b0, {9'h100,9'd5}, {9'h100,9'd6}, 41'h0FFFFFC0000, 41'd0},
    {1'b1,1'b1,1'b0,1'b1,1'b0, {9'd20,9'd1}, {9'd30,9'd1}, 41'd0, 41'h00000C00000},
    {1'b0,1'b0,1'b0,1'b0,1'b1, 18'd4, 18'h3FFFD, 41'd777, 41'd0}
  };

  // independent model in 64-bit integers, all stages bypassed
  function automatic logic [41:0] ref_mac(input logic sp, input logic sb, input logic sh,
      input logic cs, input logic fb, input logic [17:0] av, input logic [17:0] bv,
      input logic [40:0] ci, input logic [40:0] cd);
    logic [40:0] c;
    longint cv, x, y, r, lo;
    logic ov;
    c = cs ? cd : (fb ? 41'd0 : ci);
    if (!sp) begin
      cv = longint'($signed(c));
      if (sh) cv = cv >>> 17;
      x = longint'($signed(av));
      y = longint'($signed(bv));
      r = sb ? cv - x * y : cv + x * y;
      ov = (r > 64'sd1099511627775) || (r < -64'sd1099511627776);
      return {ov, r[40:0]};
    end
    cv = longint'($signed(c[40:18]));
    x  = longint'($signed(av[17:9]));
    y  = longint'($signed(bv[17:9]));
    r  = sb ? cv - x * y : cv + x * y;
    lo = longint'($signed(av[8:0])) * longint'($signed(bv[8:0]));
    ov = (r > 64'sd4194303) || (r < -64'sd4194304);
    return {ov, r[22:0], lo[17:0]};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    split_mode = 0; sub = 0; shift_en = 0; casc_sel = 0; fb_sel = 0;
    a = 18'd5; b = 18'd5; c_in = '0; casc_in = '0;
    a_bypass = 2'b00; b_bypass = 2'b00; p_bypass = 2'b00; ctl_bypass = 4'h0;
    a_en = 2'b11; b_en = 2'b11; p_en = 2'b11; ctl_en = 4'hF;
    a_srst_n = 2'b11; b_srst_n = 2'b11; p_srst_n = 2'b11; ctl_srst_n = 4'hF;
    a_arst_n = 2'b00; b_arst_n = 2'b00; p_arst_n = 2'b00; ctl_arst_n = 4'h0;
    #1;
    check("R11 reset value", 64'({ovfl, p}), 64'd0);
    @(negedge clk);
    a_arst_n = 2'b11; b_arst_n = 2'b11; p_arst_n = 2'b11; ctl_arst_n = 4'hF;
    a_bypass = 2'b11; b_bypass = 2'b11; ctl_bypass = 4'hF;
    a = 18'd3; b = 18'd5; fb_sel = 1;
    // R6 feedback accumulates 15 per edge
    tick(); tick(); tick();
    check("R6 feedback accumulate", 64'(p), 64'd45);
    // R9 sub through its register: one edge of latency
    @(negedge clk); ctl_bypass = 4'b1110; sub = 1;
    tick();
    check("R9 ctl reg latency", 64'(p), 64'd60);
    tick();
    check("R9 ctl reg applied", 64'(p), 64'd45);
    @(negedge clk); ctl_bypass = 4'hF; sub = 0;
    // R10 hold with enable low
    p_en = 2'b00; a = 18'd100;
    tick(); tick();
    check("R10 enable hold", 64'({ovfl, p}), 64'd45);
    // R11 sync reset beats enable
    @(negedge clk); p_en = 2'b11; p_srst_n = 2'b00;
    tick();
    check("R11 sync reset", 64'(p), 64'd0);
    @(negedge clk); p_srst_n = 2'b11;
    tick();
    check("R6 feedback from zero", 64'(p), 64'd500);
    @(negedge clk); p_arst_n = 2'b00;
    #1;
    check("R11 async reset immediate", 64'(p), 64'd0);
    @(negedge clk); p_arst_n = 2'b11;
    // R2 R3 R8: split lanes with feedback, low lane never accumulates
    split_mode = 1; a = {9'd2, 9'd7}; b = {9'd3, 9'h1FC};
    tick();
    check("R3 split high first", 64'(p), 64'({23'd6, 18'h3FFE4}));
    tick();
    check("R2 R8 split lanes second", 64'({ovfl, p}), 64'({1'b0, 23'd12, 18'h3FFE4}));
    // R9 low operand half registered, high half bypassed
    @(negedge clk);
    p_bypass = 2'b11; fb_sel = 0; c_in = '0; a_bypass = 2'b10;
    a = {9'd1, 9'd5}; b = {9'd1, 9'd2};
    #1;
    check("R9 low half old operand", 64'(p), 64'({23'd1, 18'd14}));
    tick();
    check("R9 low half new operand", 64'(p), 64'({23'd1, 18'd10}));
    // R13 illegal feedback with high result bypassed
    @(negedge clk);
    a_bypass = 2'b11; split_mode = 0; fb_sel = 1; a = 18'd4; b = 18'h3FFFD; c_in = 41'd99;
    #1;
    check("R13 config_error flag", 64'(config_error), 64'd1);
    check("R13 C forced zero", 64'(p), 64'(41'h1FFFFFFFFF4));
    // table: R1 R4 R5 R6 R7 R8 R12, all stages bypassed
    for (int i = 0; i < NV; i++) begin
      logic [41:0] exp;
      @(negedge clk);
      {split_mode, sub, shift_en, casc_sel, fb_sel, a, b, c_in, casc_in} = VEC[i];
      #1;
      exp = ref_mac(split_mode, sub, shift_en, casc_sel, fb_sel, a, b, c_in, casc_in);
      check(split_mode ? "R2 R3 R5 R8 split row" : "R1 R4 R6 R7 full row",
            64'({ovfl, p}), 64'(exp));
      check("R12 cascade mirror", 64'(casc_out), 64'(exp[40:0]));
      check("R13 flag per row", 64'(config_error), 64'(fb_sel && !casc_sel));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule